// File: doc/BRIEF.md
# Two-Layer ARGB Alpha Blender

This block composites a foreground pixel over a background pixel. Both pixels arrive as 32-bit ARGB words with 8 bits per channel. The result is one blended 32-bit ARGB pixel for every accepted input pair. The block uses the full "over" operator. It first forms a product alpha of the two layers. From that it derives an output alpha, and then it normalises each colour channel by dividing by that output alpha. Every division truncates.

Either layer can be replaced by a fixed colour input, chosen per pixel by a source-select field. A fixed layer is fully opaque before its alpha modifier is applied, and its pixel stream is not consumed. Each layer has its own alpha modifier. The modifier can keep the incoming alpha, replace it with a constant, or scale it by that constant. The datapath is a four-stage pipeline with valid/ready flow control on both inputs and on the output.

Top module: `argb_over_blend`

## Requirements
- R1: Each colour channel C of the output equals floor((C_fg·a_fg + C_bg·a_bg − C_bg·a_m) / a_out). Here a_fg and a_bg are the layer alphas after their modifiers, and the pixel bit layout is A[31:24], R[23:16], G[15:8], B[7:0].
- R2: With a_m = floor(a_fg·a_bg / 255), the output alpha bits [31:24] equal a_out = a_fg + a_bg − a_m, and a_out is never below either layer alpha.
- R3: Alpha-mode code 00 and code 11 leave the layer alpha unchanged, whatever the layer's constant is.
- R4: Alpha-mode code 01 replaces the layer alpha with the layer's constant.
- R5: Alpha-mode code 10 sets the layer alpha to floor(incoming·constant / 255).
- R6: Source code 01 (fixed foreground) takes foreground RGB from `fg_fix_rgb` with alpha 0xFF before modification. It holds `fg_ready` low and ignores `fg_pix`.
- R7: Source code 10 (fixed background) takes background RGB from `bg_fix_rgb` with alpha 0xFF before modification. It holds `bg_ready` low and ignores `bg_pix`.
- R8: When a_out is 0, the output RGB bits are 0.
- R9: With `out_ready` high, a pair accepted at clock edge k appears at the output after edge k+3. Pairs accepted on consecutive edges leave on consecutive edges, in order.
- R10: While `out_valid` is high and `out_ready` is low, `out_pix` and `out_valid` hold. The input ready signals stay low, and no pixel is lost.
- R11: Source codes 00 and 11 (two-source blend) accept a pair only when both `fg_valid` and `bg_valid` are high. Neither ready signal is asserted without the other stream being valid.
- R12: After synchronous reset, `out_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_mode | input | 2 | Per-pixel source select: 00/11 both, 01 fixed foreground, 10 fixed background |
| fg_valid | input | 1 | Foreground pixel valid |
| fg_ready | output | 1 | Foreground pixel accepted this edge |
| fg_pix | input | 32 | Foreground ARGB pixel |
| bg_valid | input | 1 | Background pixel valid |
| bg_ready | output | 1 | Background pixel accepted this edge |
| bg_pix | input | 32 | Background ARGB pixel |
| fg_fix_rgb | input | 24 | Fixed foreground RGB |
| bg_fix_rgb | input | 24 | Fixed background RGB |
| fg_amode | input | 2 | Foreground alpha-mode code |
| fg_kalpha | input | 8 | Foreground constant alpha |
| bg_amode | input | 2 | Background alpha-mode code |
| bg_kalpha | input | 8 | Background constant alpha |
| out_valid | output | 1 | Blended pixel valid |
| out_ready | input | 1 | Downstream accepts blended pixel |
| out_pix | output | 32 | Blended ARGB pixel |

## Verification
Some properties are checked on every cycle by assertions:
- the output holds under backpressure;
- a zero output alpha gives zero colour;
- the output alpha is never below either layer alpha;
- a fixed layer never raises its ready;
- in two-source mode, ready is never raised toward a lone valid stream.

Other behaviour only the bench scenarios can show. This covers the arithmetic values under truncation, each alpha-mode code, the use of the fixed colours, the exact four-edge latency with back-to-back ordering, and the absence of loss across a stall.

// File: rtl/blend_pkg.sv
package blend_pkg;
  typedef enum logic [1:0] {
    SRC_BOTH     = 2'b00,
    SRC_FIX_FG   = 2'b01,
    SRC_FIX_BG   = 2'b10,
    SRC_BOTH_ALT = 2'b11
  } src_mode_e;

  typedef enum logic [1:0] {
    AM_KEEP     = 2'b00,
    AM_REPLACE  = 2'b01,
    AM_SCALE    = 2'b10,
    AM_KEEP_ALT = 2'b11
  } alpha_mode_e;
endpackage

// File: rtl/alpha_mod.sv
module alpha_mod
  import blend_pkg::*;
#(
  parameter int CH_W = 8
) (
  input  logic [1:0]      amode,
  input  logic [CH_W-1:0] kalpha,
  input  logic [CH_W-1:0] a_in,
  output logic [CH_W-1:0] a_out
);
  localparam int PW = 2 * CH_W;
  localparam logic [PW-1:0] FULL = PW'((1 << CH_W) - 1);

  logic [PW-1:0] prod;
  logic [PW-1:0] quot;

  always_comb begin
    prod = PW'(a_in) * PW'(kalpha);
    quot = prod / FULL;
    case (alpha_mode_e'(amode))
      AM_REPLACE: a_out = kalpha;
      AM_SCALE:   a_out = quot[CH_W-1:0];
      default:    a_out = a_in;
    endcase
  end
endmodule

// File: rtl/blend_chan.sv
module blend_chan #(
  parameter int CH_W = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            en,
  input  logic [CH_W-1:0] c_fg,
  input  logic [CH_W-1:0] c_bg,
  input  logic [CH_W-1:0] a_fg,
  input  logic [CH_W-1:0] a_bg_rem,
  input  logic [CH_W-1:0] div_a,
  output logic [CH_W-1:0] q
);
  localparam int NW = 2 * CH_W + 1;

  logic [NW-1:0] num_r;
  logic [NW-1:0] num_d;
  logic [NW-1:0] quot;

  always_comb begin
    num_d = NW'(c_fg) * NW'(a_fg) + NW'(c_bg) * NW'(a_bg_rem);
    quot  = (div_a == '0) ? '0 : num_r / NW'(div_a);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      num_r <= '0;
      q     <= '0;
    end else if (en) begin
      num_r <= num_d;
      q     <= quot[CH_W-1:0];
    end
  end
endmodule

// File: rtl/argb_over_blend.sv
module argb_over_blend
  import blend_pkg::*;
#(
  parameter int CH_W = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [1:0]          src_mode,
  input  logic                fg_valid,
  output logic                fg_ready,
  input  logic [4*CH_W-1:0]   fg_pix,
  input  logic                bg_valid,
  output logic                bg_ready,
  input  logic [4*CH_W-1:0]   bg_pix,
  input  logic [3*CH_W-1:0]   fg_fix_rgb,
  input  logic [3*CH_W-1:0]   bg_fix_rgb,
  input  logic [1:0]          fg_amode,
  input  logic [CH_W-1:0]     fg_kalpha,
  input  logic [1:0]          bg_amode,
  input  logic [CH_W-1:0]     bg_kalpha,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [4*CH_W-1:0]   out_pix
);
  localparam int RGB_W = 3 * CH_W;
  localparam int PW    = 2 * CH_W;
  localparam logic [CH_W-1:0] OPAQUE = '1;
  localparam logic [PW-1:0]   FULL   = PW'((1 << CH_W) - 1);

  // flow control: whole pipeline advances together
  logic advance, fix_fg, fix_bg, need_fg, need_bg, take;
  always_comb begin
    advance  = !out_valid || out_ready;
    fix_fg   = (src_mode_e'(src_mode) == SRC_FIX_FG);
    fix_bg   = (src_mode_e'(src_mode) == SRC_FIX_BG);
    need_fg  = !fix_fg;
    need_bg  = !fix_bg;
    fg_ready = advance && need_fg && (!need_bg || bg_valid);
    bg_ready = advance && need_bg && (!need_fg || fg_valid);
    take     = advance && (!need_fg || fg_valid) && (!need_bg || bg_valid);
  end

  // source selection and alpha modifiers
  logic [CH_W-1:0]  fg_a_raw, bg_a_raw, fg_a_mod, bg_a_mod;
  logic [RGB_W-1:0] fg_rgb, bg_rgb;
  always_comb begin
    fg_a_raw = fix_fg ? OPAQUE : fg_pix[4*CH_W-1:RGB_W];
    fg_rgb   = fix_fg ? fg_fix_rgb : fg_pix[RGB_W-1:0];
    bg_a_raw = fix_bg ? OPAQUE : bg_pix[4*CH_W-1:RGB_W];
    bg_rgb   = fix_bg ? bg_fix_rgb : bg_pix[RGB_W-1:0];
  end

  alpha_mod #(.CH_W(CH_W)) u_fg_am (
    .amode(fg_amode), .kalpha(fg_kalpha), .a_in(fg_a_raw), .a_out(fg_a_mod));
  alpha_mod #(.CH_W(CH_W)) u_bg_am (
    .amode(bg_amode), .kalpha(bg_kalpha), .a_in(bg_a_raw), .a_out(bg_a_mod));

  // stage 1: selected, modified layers
  logic             s1_v;
  logic [CH_W-1:0]  s1_afg, s1_abg;
  logic [RGB_W-1:0] s1_cfg, s1_cbg;
  always_ff @(posedge clk) begin
    if (rst) begin
      s1_v <= 1'b0; s1_afg <= '0; s1_abg <= '0; s1_cfg <= '0; s1_cbg <= '0;
    end else if (advance) begin
      s1_v   <= take;
      s1_afg <= fg_a_mod;
      s1_abg <= bg_a_mod;
      s1_cfg <= fg_rgb;
      s1_cbg <= bg_rgb;
    end
  end

  // stage 2: product alpha and output alpha
  logic [PW-1:0]   am_prod, am_quot;
  logic [CH_W-1:0] a_mult;
  always_comb begin
    am_prod = PW'(s1_afg) * PW'(s1_abg);
    am_quot = am_prod / FULL;
    a_mult  = am_quot[CH_W-1:0];
  end

  logic             s2_v;
  logic [CH_W-1:0]  s2_afg, s2_abg, s2_brem, s2_aout;
  logic [RGB_W-1:0] s2_cfg, s2_cbg;
  always_ff @(posedge clk) begin
    if (rst) begin
      s2_v <= 1'b0; s2_afg <= '0; s2_abg <= '0; s2_brem <= '0; s2_aout <= '0;
      s2_cfg <= '0; s2_cbg <= '0;
    end else if (advance) begin
      s2_v    <= s1_v;
      s2_afg  <= s1_afg;
      s2_abg  <= s1_abg;
      s2_brem <= s1_abg - a_mult;
      s2_aout <= s1_afg + (s1_abg - a_mult);
      s2_cfg  <= s1_cfg;
      s2_cbg  <= s1_cbg;
    end
  end

  // stage 3 and 4 live partly in the channel units
  logic            s3_v, s4_v;
  logic [CH_W-1:0] s3_aout, s4_aout;
  always_ff @(posedge clk) begin
    if (rst) begin
      s3_v <= 1'b0; s4_v <= 1'b0; s3_aout <= '0; s4_aout <= '0;
    end else if (advance) begin
      s3_v    <= s2_v;
      s3_aout <= s2_aout;
      s4_v    <= s3_v;
      s4_aout <= s3_aout;
    end
  end

  logic [RGB_W-1:0] rgb_q;
  for (genvar gi = 0; gi < 3; gi++) begin : g_chan
    blend_chan #(.CH_W(CH_W)) u_chan (
      .clk(clk), .rst(rst), .en(advance),
      .c_fg(s2_cfg[gi*CH_W +: CH_W]),
      .c_bg(s2_cbg[gi*CH_W +: CH_W]),
      .a_fg(s2_afg),
      .a_bg_rem(s2_brem),
      .div_a(s3_aout),
      .q(rgb_q[gi*CH_W +: CH_W]));
  end

  assign out_valid = s4_v;
  assign out_pix   = {s4_aout, rgb_q};

  // assertions
  p_alpha_bound_r2: assert property (@(posedge clk) disable iff (rst)
    s2_v |-> (s2_aout >= s2_afg) && (s2_aout >= s2_abg));
  p_zero_rgb_r8: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_pix[4*CH_W-1:RGB_W] == '0) |-> (out_pix[RGB_W-1:0] == '0));
  p_fg_idle_r6: assert property (@(posedge clk) disable iff (rst)
    (src_mode == 2'b01) |-> !fg_ready);
  p_bg_idle_r7: assert property (@(posedge clk) disable iff (rst)
    (src_mode == 2'b10) |-> !bg_ready);
  p_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_pix)));
  p_stall_r10: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |-> (!fg_ready && !bg_ready));
  p_pair_r11: assert property (@(posedge clk) disable iff (rst)
    (src_mode == 2'b00 || src_mode == 2'b11) |->
      ((!fg_ready || bg_valid) && (!bg_ready || fg_valid)));
endmodule

// File: tb/argb_over_blend_bench.sv
module argb_over_blend_bench;
  typedef struct packed {
    logic [1:0]  mode;
    logic [31:0] fg;
    logic [31:0] bg;
    logic [23:0] ffix;
    logic [23:0] bfix;
    logic [1:0]  fam;
    logic [7:0]  fka;
    logic [1:0]  bam;
    logic [7:0]  bka;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 32'h80FF0000, 32'hFF0000FF, 24'h0, 24'h0, 2'd0, 8'h00, 2'd0, 8'h00},
    '{2'd0, 32'h4C1234F0, 32'hB3ABCDEF, 24'h0, 24'h0, 2'd0, 8'h00, 2'd0, 8'h00},
    '{2'd3, 32'h01FFFFFF, 32'h01000000, 24'h0, 24'h0, 2'd3, 8'h77, 2'd3, 8'h11},
    '{2'd0, 32'hFF102030, 32'h7F405060, 24'h0, 24'h0, 2'd2, 8'h33, 2'd1, 8'hC8},
    '{2'd0, 32'h00FFFFFF, 32'h00FFFFFF, 24'h0, 24'h0, 2'd0, 8'h00, 2'd0, 8'h00},
    '{2'd1, 32'hDEADBEEF, 32'h9955AA33, 24'h10E0F0, 24'h0, 2'd2, 8'h66, 2'd0, 8'h00},
    '{2'd2, 32'h3C808080, 32'h12345678, 24'h0, 24'h204060, 2'd0, 8'h00, 2'd1, 8'h90},
    '{2'd0, 32'hFEFEFEFE, 32'h01010101, 24'h0, 24'h0, 2'd2, 8'hFF, 2'd2, 8'h01},
    '{2'd1, 32'h00000000, 32'hFF0000FF, 24'h00FF00, 24'h0, 2'd2, 8'h80, 2'd0, 8'h00},
    '{2'd2, 32'h00123456, 32'hAAAAAAAA, 24'h0, 24'h0000FF, 2'd0, 8'h00, 2'd0, 8'h00}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  src_mode = '0;
  logic        fg_valid = 1'b0, bg_valid = 1'b0, out_ready = 1'b1;
  logic        fg_ready, bg_ready, out_valid;
  logic [31:0] fg_pix = '0, bg_pix = '0, out_pix;
  logic [23:0] fg_fix_rgb = '0, bg_fix_rgb = '0;
  logic [1:0]  fg_amode = '0, bg_amode = '0;
  logic [7:0]  fg_kalpha = '0, bg_kalpha = '0;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  argb_over_blend u_argb_over_blend (
    .clk(clk), .rst(rst), .src_mode(src_mode),
    .fg_valid(fg_valid), .fg_ready(fg_ready), .fg_pix(fg_pix),
    .bg_valid(bg_valid), .bg_ready(bg_ready), .bg_pix(bg_pix),
    .fg_fix_rgb(fg_fix_rgb), .bg_fix_rgb(bg_fix_rgb),
    .fg_amode(fg_amode), .fg_kalpha(fg_kalpha),
    .bg_amode(bg_amode), .bg_kalpha(bg_kalpha),
    .out_valid(out_valid), .out_ready(out_ready), .out_pix(out_pix));

  function automatic int amod(int am, int k, int a);
    if (am == 1) return k;
    if (am == 2) return (a * k) / 255;
    return a;
  endfunction

  function automatic logic [31:0] model(vec_t v);
    int fa, ba, am, ao;
    logic [23:0] fr, br;
    logic [31:0] r;
    fa = (v.mode == 2'd1) ? 255 : int'(v.fg[31:24]);
    fr = (v.mode == 2'd1) ? v.ffix : v.fg[23:0];
    ba = (v.mode == 2'd2) ? 255 : int'(v.bg[31:24]);
    br = (v.mode == 2'd2) ? v.bfix : v.bg[23:0];
    fa = amod(int'(v.fam), int'(v.fka), fa);
    ba = amod(int'(v.bam), int'(v.bka), ba);
    am = (fa * ba) / 255;
    ao = fa + ba - am;
    r[31:24] = 8'(ao);
    for (int c = 0; c < 3; c++) begin
      int cf, cb;
      cf = int'(fr[c*8 +: 8]);
      cb = int'(br[c*8 +: 8]);
      r[c*8 +: 8] = (ao == 0) ? 8'h00 : 8'((cf * fa + cb * ba - cb * am) / ao);
    end
    return r;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive(vec_t v, bit all_valid);
    src_mode = v.mode; fg_pix = v.fg; bg_pix = v.bg;
    fg_fix_rgb = v.ffix; bg_fix_rgb = v.bfix;
    fg_amode = v.fam; fg_kalpha = v.fka; bg_amode = v.bam; bg_kalpha = v.bka;
    fg_valid = all_valid || (v.mode != 2'd1);
    bg_valid = all_valid || (v.mode != 2'd2);
  endtask

  task automatic send(vec_t v, bit all_valid);
    @(negedge clk);
    drive(v, all_valid);
    forever begin
      #1;
      if ((v.mode == 2'd1) ? bg_ready : fg_ready) break;
      @(negedge clk);
    end
    @(posedge clk);
    #1;
    fg_valid = 1'b0; bg_valid = 1'b0;
  endtask

  task automatic get(output logic [31:0] p);
    @(negedge clk);
    while (!out_valid) @(negedge clk);
    p = out_pix;
  endtask

  task automatic run1(string req, vec_t v, logic [31:0] exp);
    logic [31:0] p;
    send(v, 1'b0);
    get(p);
    chk(req, p, exp);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    n_chk++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] p, q0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R12 reset out_valid", {31'b0, out_valid}, 32'h0);
    rst = 1'b0;

    // table walk: R1 R2 R3 R4 R5 R6 R7 R8 against the bench model
    for (int i = 0; i < NV; i++) run1("R1 table vector", VECS[i], model(VECS[i]));

    // directed hand-computed values
    run1("R1 opaque fg wins", '{2'd0, 32'hFF112233, 32'hFF445566, 24'h0, 24'h0, 2'd0, 8'h00, 2'd0, 8'h00}, 32'hFF112233);
    run1("R1 half fg over opaque bg", VECS[0], 32'hFF80007F);
    run1("R1 clear fg shows bg", '{2'd0, 32'h00FFFFFF, 32'hFF123456, 24'h0, 24'h0, 2'd0, 8'h00, 2'd0, 8'h00}, 32'hFF123456);
    run1("R2 two half layers", '{2'd0, 32'h80FF0000, 32'h80000000, 24'h0, 24'h0, 2'd0, 8'h00, 2'd0, 8'h00}, 32'hC0AA0000);
    run1("R3 code 11 keeps alpha", '{2'd0, 32'h20AABBCC, 32'h00000000, 24'h0, 24'h0, 2'd3, 8'h00, 2'd0, 8'h00}, 32'h20AABBCC);
    run1("R4 replace alpha", '{2'd0, 32'h10AABBCC, 32'h00000000, 24'h0, 24'h0, 2'd1, 8'h40, 2'd0, 8'h00}, 32'h40AABBCC);
    run1("R5 scale alpha", '{2'd0, 32'hFFFFFFFF, 32'h00000000, 24'h0, 24'h0, 2'd2, 8'h80, 2'd0, 8'h00}, 32'h80FFFFFF);
    run1("R8 zero alpha gives zero", VECS[4], 32'h00000000);

    // R6: fixed fg, fg stream valid but must not be taken, fg_pix ignored
    @(negedge clk);
    drive('{2'd1, 32'h12345678, 32'hFF0000FF, 24'h00FF00, 24'h0, 2'd2, 8'h80, 2'd0, 8'h00}, 1'b1);
    #1;
    chk("R6 fg_ready low in fixed fg", {31'b0, fg_ready}, 32'h0);
    @(posedge clk); #1; fg_valid = 1'b0; bg_valid = 1'b0;
    get(p);
    chk("R6 fixed fg colour used", p, 32'hFF00807F);

    // R7: fixed bg
    @(negedge clk);
    drive(VECS[9], 1'b1);
    #1;
    chk("R7 bg_ready low in fixed bg", {31'b0, bg_ready}, 32'h0);
    @(posedge clk); #1; fg_valid = 1'b0; bg_valid = 1'b0;
    get(p);
    chk("R7 fixed bg colour used", p, 32'hFF0000FF);

    // R11: lone fg stream in two-source mode is not accepted
    @(negedge clk);
    drive(VECS[1], 1'b0);
    bg_valid = 1'b0;
    for (int k = 0; k < 6; k++) begin
      #1;
      chk("R11 no ready without pair", {30'b0, fg_ready, out_valid}, 32'h0);
      @(negedge clk);
    end
    bg_valid = 1'b1;
    #1;
    chk("R11 ready once paired", {31'b0, fg_ready}, 32'h1);
    @(posedge clk); #1; fg_valid = 1'b0; bg_valid = 1'b0;
    get(p);
    chk("R11 paired result", p, model(VECS[1]));

    // R9: latency and back-to-back ordering
    repeat (2) @(negedge clk);
    drive(VECS[1], 1'b0);
    @(posedge clk);
    @(negedge clk);
    drive(VECS[3], 1'b0);
    @(posedge clk);
    @(negedge clk);
    drive(VECS[7], 1'b0);
    @(posedge clk);
    #1; fg_valid = 1'b0; bg_valid = 1'b0;
    @(negedge clk);
    chk("R9 not yet at third edge", {31'b0, out_valid}, 32'h0);
    @(negedge clk);
    chk("R9 first out after fourth edge", {out_valid ? out_pix : 32'hxxxxxxxx}, model(VECS[1]));
    @(negedge clk);
    chk("R9 second back-to-back", out_pix, model(VECS[3]));
    @(negedge clk);
    chk("R9 third back-to-back", out_pix, model(VECS[7]));
    @(negedge clk);
    chk("R9 drained", {31'b0, out_valid}, 32'h0);

    // R10: backpressure
    out_ready = 1'b0;
    send(VECS[5], 1'b0);
    send(VECS[6], 1'b0);
    @(negedge clk);
    while (!out_valid) @(negedge clk);
    q0 = out_pix;
    chk("R10 head value", q0, model(VECS[5]));
    drive(VECS[2], 1'b0);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk); #1;
      chk("R10 held while stalled", out_valid ? out_pix : 32'hxxxxxxxx, q0);
      chk("R10 inputs stalled", {31'b0, fg_ready}, 32'h0);
    end
    out_ready = 1'b1;
    @(posedge clk); #1; fg_valid = 1'b0; bg_valid = 1'b0;
    get(p);
    chk("R10 second not lost", p, model(VECS[6]));
    get(p);
    chk("R10 third not lost", p, model(VECS[2]));

    // R12: reset clears a busy pipeline
    send(VECS[1], 1'b0);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    repeat (4) begin
      @(negedge clk);
      chk("R12 flushed by reset", {31'b0, out_valid}, 32'h0);
    end

    finish_run();
  end
endmodule